// File: doc/BRIEF.md
# Event Interrupt Status Controller

This block gathers the condition signals from an SPI data path and records them in a sticky status register. The conditions are an illegal register access, received data present (word and byte granularity), receive FIFO full, half-full and trigger level, transmit FIFO full, half-full, empty and trigger level, and a transfer-complete trigger. Software reads the status, chooses which bits may raise an interrupt through an enable register, and acknowledges bits through a write-one-to-clear register. All three registers sit on a simple single-cycle register bus. The FIFOs and the serial engine are outside the block and appear only as condition inputs.

A status bit is set while its condition is high. A clear therefore removes the bit only if the condition has gone away. Software can clear a flag and read it again to sample the live state of a level condition, for example whether the transmit FIFO is still full. Pulse events such as an illegal access stay latched until they are cleared. One level-high interrupt output is driven from the enabled status bits.

Top module: `irq_event_ctrl`

## Requirements
- R1: Status bit positions are: TX trigger 0, TX empty 1, TX half-full 2, TX full 3, RX trigger 5, RX word-data-present 6, RX half-full 7, RX full 8, all-done 9, RX byte-data-present 11, illegal access 12. Bits 4, 10 and 13 to 31 read as zero, and condition inputs 4 and 10 have no effect.
- R2: The status register is at byte offset 0x30, the enable register at 0x34 and the clear register at 0x38. A read returns data in the same cycle as `bus_sel_i`=1 with `bus_wr_i`=0. A read of any other offset, and the read data when no read is selected, is zero.
- R3: When a condition input is high at a clock edge, its status bit reads 1 after that edge.
- R4: A status bit stays 1 after its condition drops and until it is cleared. A one-cycle illegal-access pulse stays latched.
- R5: Writing 1 to a clear-register bit clears that status bit at the write edge. Writing 0 leaves the bit unchanged.
- R6: If a condition is high at the same edge as its clear, the bit reads 1 after the clear (set wins over clear).
- R7: `irq_o` is high exactly when some status bit and the matching enable bit are both 1. An enable write takes effect on the edge that performs it.
- R8: Writes to the status register change nothing. Enable bits at unused positions are not stored and read as zero.
- R9: Reset clears all status and enable bits and holds `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 13 | Condition inputs, indexed by status bit position |
| bus_sel_i | input | 1 | Register bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
The bench clears a bit while its condition is still high. A design where clear beats set would read 0 there and lose the live level. It pulses illegal access for one cycle and checks that the bit stays latched. A design that tracks the level instead of latching it would drop the flag. It also drives the reserved condition inputs, writes to the read-only status offset and writes all ones to the enable register, so a decoder that aliases offsets or stores unused bits shows up as a wrong read value or a spurious interrupt. A long random phase compares read data and the interrupt against a behavioural model on every clock, which exposes any off-by-one-cycle capture.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int STAT_W = 13;
    localparam int DATA_W = 32;

    // status bit positions
    localparam int B_TX_TRIG  = 0;
    localparam int B_TX_EMPTY = 1;
    localparam int B_TX_HALF  = 2;
    localparam int B_TX_FULL  = 3;
    localparam int B_RX_TRIG  = 5;
    localparam int B_RX_WORD  = 6;
    localparam int B_RX_HALF  = 7;
    localparam int B_RX_FULL  = 8;
    localparam int B_DONE     = 9;
    localparam int B_RX_BYTE  = 11;
    localparam int B_ILLEGAL  = 12;

    localparam logic [STAT_W-1:0] IMPL_MASK =
        STAT_W'((1 << B_TX_TRIG) | (1 << B_TX_EMPTY) | (1 << B_TX_HALF) |
                (1 << B_TX_FULL) | (1 << B_RX_TRIG) | (1 << B_RX_WORD) |
                (1 << B_RX_HALF) | (1 << B_RX_FULL) | (1 << B_DONE) |
                (1 << B_RX_BYTE) | (1 << B_ILLEGAL));

    localparam logic [7:0] OFS_STATUS = 8'h30;
    localparam logic [7:0] OFS_ENABLE = 8'h34;
    localparam logic [7:0] OFS_CLEAR  = 8'h38;

    typedef struct packed {
        logic [STAT_W-1:0] status;
    } bank_state_t;

    typedef struct packed {
        logic [STAT_W-1:0] enable;
    } regif_state_t;
endpackage

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
    import irqc_pkg::*;
#(
    parameter int W = STAT_W,
    parameter logic [W-1:0] MASK = IMPL_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] st_o
);
    logic [W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            if (MASK[i]) begin
                // set has priority over clear
                st_d[i] = evt_i[i] | (st_q[i] & ~clr_i[i]);
            end else begin
                st_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    for (genvar g = 0; g < W; g++) begin : g_chk
        if (MASK[g]) begin : g_impl
            p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[g] |=> st_q[g]);
            p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q[g] && !clr_i[g]) |=> st_q[g]);
            p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !evt_i[g]) |=> !st_q[g]);
        end else begin : g_rsv
            p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> !st_q[g]);
        end
    end
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [STAT_W-1:0] MASK = IMPL_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] st_i,
    output logic [STAT_W-1:0] clr_o,
    output logic [STAT_W-1:0] en_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLEAR);

    regif_state_t s_d, s_q;
    logic wr_en, wr_clr, rd;

    always_comb begin
        wr_en  = sel_i && wr_i && (addr_i == A_EN);
        wr_clr = sel_i && wr_i && (addr_i == A_CLR);
        rd     = sel_i && !wr_i;

        s_d = s_q;
        if (wr_en) s_d.enable = wdata_i[STAT_W-1:0] & MASK;

        clr_o = wr_clr ? wdata_i[STAT_W-1:0] : '0;

        rdata_o = '0;
        if (rd) begin
            if (addr_i == A_STAT)    rdata_o = DATA_W'(st_i);
            else if (addr_i == A_EN) rdata_o = DATA_W'(s_q.enable);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o = s_q.enable;

    p_en_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.enable == ($past(wdata_i[STAT_W-1:0]) & MASK)));
    p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.enable));
endmodule

// File: rtl/irqc_irq_combine.sv
module irqc_irq_combine
    import irqc_pkg::*;
#(
    parameter int W = STAT_W
) (
    input  logic [W-1:0] st_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);
    always_comb begin
        irq_o = |(st_i & en_i);
    end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] st, clr, en;

    irqc_status_bank #(.W(STAT_W), .MASK(IMPL_MASK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .clr_i (clr),
        .st_o  (st)
    );

    irqc_regif #(.ADDR_W(ADDR_W), .MASK(IMPL_MASK)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (bus_sel_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .st_i    (st),
        .clr_o   (clr),
        .en_o    (en),
        .rdata_o (bus_rdata_o)
    );

    irqc_irq_combine #(.W(STAT_W)) u_comb (
        .st_i  (st),
        .en_i  (en),
        .irq_o (irq_o)
    );

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'(OFS_ENABLE) &&
         bus_wdata_i[STAT_W-1:0] == '0) |=> !irq_o);
    p_irq_reset_r9: assert property (@(posedge clk)
        !rst_n |-> !irq_o);
endmodule

// File: tb/test_irq_event_ctrl.sv
module test_irq_event_ctrl;
    localparam logic [12:0] MSK = 13'h1BEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, failures = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    logic [12:0] m_st = '0, m_en = '0;

    always #2 clk = ~clk;  // 250 MHz

    irq_event_ctrl i_irq_event_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference model
    always @(posedge clk) begin
        logic [12:0] clrv;
        if (!rst_n) begin
            m_st = '0; m_en = '0;
        end else begin
            clrv = (sel && wr && addr == 8'h38) ? wdata[12:0] : 13'h0;
            m_st = ((m_st & ~clrv) | evt) & MSK;
            if (sel && wr && addr == 8'h34) m_en = wdata[12:0] & MSK;
        end
    end

    function automatic logic [31:0] exp_rd();
        if (!(sel && !wr)) return 32'h0;
        if (addr == 8'h30) return {19'h0, m_st};
        if (addr == 8'h34) return {19'h0, m_en};
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against model
    always @(negedge clk) begin
        if (chk_on) begin
            check("R7 irq vs model", {31'h0, irq}, {31'h0, |(m_st & m_en)});
            check("R2 rdata vs model", rdata, exp_rd());
        end
    end

    task automatic cyc(); @(posedge clk); #1; endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        sel = 1; wr = 0; addr = a;
        @(negedge clk);
        check(tag, rdata, exp);
        @(posedge clk); #1;
        sel = 0;
    endtask

    task automatic wrr(logic [7:0] a, logic [31:0] d);
        sel = 1; wr = 1; addr = a; wdata = d;
        cyc();
        sel = 0; wr = 0; wdata = '0;
    endtask

    task automatic chk_irq(logic exp, string tag);
        @(negedge clk);
        check(tag, {31'h0, irq}, {31'h0, exp});
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        evt = 13'h1FFF;  // conditions during reset must not register
        repeat (3) @(posedge clk);
        #1 evt = '0;
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R9 reset state
        rd(8'h30, 32'h0, "R9 status after reset");
        rd(8'h34, 32'h0, "R9 enable after reset");
        chk_irq(1'b0, "R9 irq after reset");

        // R3 / R4: TX full (bit 3) one-cycle condition
        evt = 13'h0008; cyc(); evt = '0;
        rd(8'h30, 32'h8, "R3 TX full captured");
        rd(8'h30, 32'h8, "R4 TX full held after drop");

        // R5: clear with 0 leaves, clear with 1 removes
        wrr(8'h38, 32'h0);
        rd(8'h30, 32'h8, "R5 clear-zero keeps bit");
        wrr(8'h38, 32'h8);
        rd(8'h30, 32'h0, "R5 clear-one removes bit");

        // R6: TX empty (bit 1) held high across clear
        evt = 13'h0002; cyc();
        wrr(8'h38, 32'h2);
        rd(8'h30, 32'h2, "R6 set wins over clear");
        evt = '0; cyc();
        wrr(8'h38, 32'h2);
        rd(8'h30, 32'h0, "R6 clear after condition gone");

        // R4: illegal access (bit 12) pulse latched
        evt = 13'h1000; cyc(); evt = '0;
        repeat (3) cyc();
        rd(8'h30, 32'h1000, "R4 illegal access latched");

        // R7: enable drives irq
        chk_irq(1'b0, "R7 irq low while masked");
        wrr(8'h34, 32'h1000);
        chk_irq(1'b1, "R7 irq high when enabled");
        wrr(8'h34, 32'h0);
        chk_irq(1'b0, "R7 irq low after disable");
        wrr(8'h38, 32'h1000);

        // R1: reserved inputs 4 and 10 ignored; all-done bit 9 and RX byte bit 11
        evt = 13'h0410; cyc(); evt = '0;
        rd(8'h30, 32'h0, "R1 reserved inputs ignored");
        evt = 13'h0A00; cyc(); evt = '0;
        rd(8'h30, 32'h0A00, "R1 done and rx byte positions");

        // R8: status write ignored, enable unused bits dropped
        wrr(8'h30, 32'h0);
        rd(8'h30, 32'h0A00, "R8 status write ignored");
        wrr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, 32'h1BEF, "R8 enable unused bits zero");
        chk_irq(1'b1, "R7 irq with all enabled");

        // R2: other offsets read zero, no-read gives zero
        rd(8'h3C, 32'h0, "R2 unmapped offset");
        rd(8'h38, 32'h0, "R2 clear reads zero");
        wrr(8'h38, 32'h1FFF);
        wrr(8'h34, 32'h0);

        // random phase, model compared every clock
        for (int n = 0; n < 3000; n++) begin
            int op;
            evt = 13'($urandom) & 13'($urandom) & 13'($urandom);
            op = $urandom_range(0, 6);
            sel = (op != 0); wr = 1'b0; wdata = $urandom;
            case (op)
                1: addr = 8'h30;
                2: addr = 8'h34;
                3: begin wr = 1'b1; addr = 8'h38; end
                4: begin wr = 1'b1; addr = 8'h34; end
                5: begin wr = 1'b1; addr = 8'h30; end
                default: addr = 8'($urandom);
            endcase
            cyc();
        end
        sel = 0; wr = 0; evt = '0;
        cyc();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule